// File: doc/BRIEF.md
# Colour Lookup Table Stream Loader

The block fills a 256-entry colour lookup table from a stream of 32-bit words delivered over a valid/ready handshake by a DMA engine. Software or a sequencer pulses `arm_i`. The block then raises `s_ready` and treats the next accepted word as the header word. Each word carries two 16-bit table entries, the low half first. Bits 11:0 of an entry are a 4:4:4 colour: red in 11:8, green in 7:4 and blue in 3:0. Bits 14:12 of the very first entry carry the pixel-format code. That code sets how many words make up the transfer.

When the last expected word has been taken, the block pulses `loaded_o` for one cycle. It keeps accepting and discarding any further words until it is armed again. A separate read port turns an 8-bit pixel index into its 12-bit colour one clock later. The table itself is not reset.

The controller has four states. ST_IDLE holds `s_ready` low. ST_HEAD waits for the header word. ST_BODY takes payload words. ST_DRAIN swallows surplus words. The transitions are as follows:
- `arm_i` moves any state to ST_HEAD.
- A header handshake moves ST_HEAD to ST_BODY.
- The handshake of the final counted word moves ST_BODY to ST_DRAIN and fires `loaded_o`.

A word presented in the same cycle as `arm_i` is not taken.

Top module: `pal_stream_loader`

## Requirements
- R1: After reset `s_ready`, `loaded_o` and `fmt_o` are all 0, and `s_ready` stays low with `s_valid` high until `arm_i` is pulsed.
- R2: `s_ready` is high in the cycle after a cycle with `arm_i` high.
- R3: `fmt_o` takes bits 14:12 of the first accepted word after arming, from the edge of that handshake, and changes at no other time.
- R4: Word k of a transfer (header = word 0) writes its bits 11:0 to table index 2k and its bits 27:16 to index 2k+1. The header's colour bits load index 0, and bits 15:12 and 31:28 never reach the table.
- R5: The transfer length in words is (palette bytes / 4) + 1. Codes 0, 1 and 2 give 256 bytes (65 words), code 3 gives 512 bytes (129 words), and codes 4 to 7 give 32 bytes (9 words).
- R6: `loaded_o` is high for exactly one cycle, the cycle after the clock edge that accepts the final counted word, and is low at all other times.
- R7: Words after the final counted word are accepted with `s_ready` high, do not change the table and do not pulse `loaded_o`.
- R8: Entries whose index would be 256 or above (the last word of a code-3 transfer) are dropped, and indices 0 and 1 keep their values.
- R9: `rd_color_o` shows the table entry at `rd_idx_i` from the clock edge after `rd_idx_i` is applied.
- R10: Pulsing `arm_i` during a transfer abandons it, so the next accepted word is a header again and the word count restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm_i | input | 1 | Start (or restart) a palette load |
| s_valid | input | 1 | Stream word valid |
| s_data | input | 32 | Stream word, two entries, low half first |
| s_ready | output | 1 | Stream word accepted when high with `s_valid` |
| loaded_o | output | 1 | One-cycle palette-loaded event |
| fmt_o | output | 3 | Latched pixel-format code |
| rd_idx_i | input | 8 | Lookup index |
| rd_color_o | output | 12 | Colour at the registered lookup index |

## Verification
The word counter and the state register are the internal state most likely to go wrong. A counter off by one, or a wrong length decode, moves the `loaded_o` pulse by a word or more. The bench catches this at the exact handshake for every format code. A broken entry-index calculation shows up as wrong colours when all 256 indices are read back after each load. A drain state that still writes is exposed the same way, a few cycles after the surplus words. A lost arm or restart appears as a stuck `s_ready` or a wrong `fmt_o` within a cycle or two.

// File: rtl/pal_pkg.sv
package pal_pkg;

    localparam int WORD_W  = 32;
    localparam int HALF_W  = 16;
    localparam int COL_W   = 12;
    localparam int FMT_LSB = 12;
    localparam int FMT_W   = 3;
    localparam int WCNT_W  = 8;

    localparam logic [FMT_W-1:0] FMT_1BPP = 3'd0;
    localparam logic [FMT_W-1:0] FMT_2BPP = 3'd1;
    localparam logic [FMT_W-1:0] FMT_4BPP = 3'd2;
    localparam logic [FMT_W-1:0] FMT_8BPP = 3'd3;
    localparam logic [FMT_W-1:0] FMT_HI   = 3'd4;

    localparam int BYTES_LOW  = 256;
    localparam int BYTES_8BPP = 512;
    localparam int BYTES_HI   = 32;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_HEAD  = 2'd1,
        ST_BODY  = 2'd2,
        ST_DRAIN = 2'd3
    } pal_state_t;

    function automatic logic [WCNT_W-1:0] words_for_fmt(input logic [FMT_W-1:0] code);
        int bytes;
        if (code == FMT_1BPP || code == FMT_2BPP || code == FMT_4BPP)
            bytes = BYTES_LOW;
        else if (code == FMT_8BPP)
            bytes = BYTES_8BPP;
        else
            bytes = BYTES_HI;
        return WCNT_W'(bytes / 4 + 1);
    endfunction

endpackage

// File: rtl/pal_ctrl.sv
module pal_ctrl
    import pal_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                arm_i,
    input  logic                valid_i,
    input  logic [FMT_W-1:0]    code_i,
    output logic                ready_o,
    output logic                wr_en_o,
    output logic [WCNT_W-1:0]   word_idx_o,
    output logic [FMT_W-1:0]    fmt_o,
    output logic                loaded_o
);

    pal_state_t         state_q, state_d;
    logic [WCNT_W-1:0]  cnt_q;
    logic [WCNT_W-1:0]  target_q;
    logic               accept;
    logic               last_word;

    assign ready_o    = (state_q != ST_IDLE);
    assign accept     = valid_i && ready_o && !arm_i;
    assign last_word  = ({1'b0, cnt_q} + 1'b1) == {1'b0, target_q};
    assign wr_en_o    = accept && (state_q == ST_HEAD || state_q == ST_BODY);
    assign word_idx_o = (state_q == ST_HEAD) ? '0 : cnt_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (arm_i) state_d = ST_HEAD;
            end
            ST_HEAD: begin
                if (arm_i)       state_d = ST_HEAD;
                else if (accept) state_d = ST_BODY;
            end
            ST_BODY: begin
                if (arm_i)                    state_d = ST_HEAD;
                else if (accept && last_word) state_d = ST_DRAIN;
            end
            ST_DRAIN: begin
                if (arm_i) state_d = ST_HEAD;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            target_q <= '0;
            fmt_o    <= '0;
            loaded_o <= 1'b0;
        end else begin
            loaded_o <= 1'b0;
            unique case (state_q)
                ST_IDLE, ST_DRAIN: begin
                    cnt_q <= '0;
                end
                ST_HEAD: begin
                    if (accept) begin
                        cnt_q    <= WCNT_W'(1);
                        target_q <= words_for_fmt(code_i);
                        fmt_o    <= code_i;
                    end
                end
                ST_BODY: begin
                    if (arm_i) begin
                        cnt_q <= '0;
                    end else if (accept) begin
                        cnt_q    <= cnt_q + 1'b1;
                        loaded_o <= last_word;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/pal_unpack.sv
module pal_unpack
    import pal_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic                         wr_en_i,
    input  logic [WCNT_W-1:0]            word_idx_i,
    input  logic [WORD_W-1:0]            word_i,
    output logic [1:0]                   we_o,
    output logic [1:0][IDX_W-1:0]        idx_o,
    output logic [1:0][COL_W-1:0]        col_o
);

    localparam int DEPTH = 1 << IDX_W;
    localparam int ENT_W = (IDX_W > WCNT_W + 1) ? IDX_W : WCNT_W + 1;
    localparam int LANES = WORD_W / HALF_W;

    for (genvar h = 0; h < LANES; h++) begin : g_lane
        logic [ENT_W-1:0] ent;
        assign ent      = ENT_W'({word_idx_i, 1'b0}) + ENT_W'(h);
        assign we_o[h]  = wr_en_i && (int'(ent) < DEPTH);
        assign idx_o[h] = ent[IDX_W-1:0];
        assign col_o[h] = word_i[h*HALF_W +: COL_W];
    end

endmodule

// File: rtl/pal_table.sv
module pal_table
    import pal_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic                   clk,
    input  logic [1:0]             we_i,
    input  logic [1:0][IDX_W-1:0]  idx_i,
    input  logic [1:0][COL_W-1:0]  col_i,
    input  logic [IDX_W-1:0]       rd_idx_i,
    output logic [COL_W-1:0]       rd_col_o
);

    localparam int DEPTH = 1 << IDX_W;

    logic [COL_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        for (int p = 0; p < 2; p++) begin
            if (we_i[p]) mem[idx_i[p]] <= col_i[p];
        end
        rd_col_o <= mem[rd_idx_i];
    end

endmodule

// File: rtl/pal_stream_loader.sv
module pal_stream_loader
    import pal_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 arm_i,
    input  logic                 s_valid,
    input  logic [WORD_W-1:0]    s_data,
    output logic                 s_ready,
    output logic                 loaded_o,
    output logic [FMT_W-1:0]     fmt_o,
    input  logic [IDX_W-1:0]     rd_idx_i,
    output logic [COL_W-1:0]     rd_color_o
);

    logic                       wr_en;
    logic [WCNT_W-1:0]          word_idx;
    logic [1:0]                 lane_we;
    logic [1:0][IDX_W-1:0]      lane_idx;
    logic [1:0][COL_W-1:0]      lane_col;

    pal_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .arm_i      (arm_i),
        .valid_i    (s_valid),
        .code_i     (s_data[FMT_LSB +: FMT_W]),
        .ready_o    (s_ready),
        .wr_en_o    (wr_en),
        .word_idx_o (word_idx),
        .fmt_o      (fmt_o),
        .loaded_o   (loaded_o)
    );

    pal_unpack #(.IDX_W(IDX_W)) u_unpack (
        .wr_en_i    (wr_en),
        .word_idx_i (word_idx),
        .word_i     (s_data),
        .we_o       (lane_we),
        .idx_o      (lane_idx),
        .col_o      (lane_col)
    );

    pal_table #(.IDX_W(IDX_W)) u_table (
        .clk      (clk),
        .we_i     (lane_we),
        .idx_i    (lane_idx),
        .col_i    (lane_col),
        .rd_idx_i (rd_idx_i),
        .rd_col_o (rd_color_o)
    );

endmodule

// File: rtl/pal_stream_loader_chk.sv
module pal_stream_loader_chk
    import pal_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             arm_i,
    input logic             s_valid,
    input logic             s_ready,
    input logic             loaded_o,
    input logic [FMT_W-1:0] fmt_o
);

    logic armed_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     armed_seen <= 1'b0;
        else if (arm_i) armed_seen <= 1'b1;
    end

    // R1: no readiness before the first arm
    p_no_ready_unarmed_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !armed_seen |-> !s_ready);

    // R2: arm opens the stream next cycle
    p_ready_after_arm_r2: assert property (@(posedge clk) disable iff (!rst_n)
        arm_i |=> s_ready);

    // R3: format changes only after a handshake
    p_fmt_on_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_o != $past(fmt_o)) |-> $past(s_valid && s_ready && !arm_i));

    // R6: event is a single cycle
    p_loaded_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        loaded_o |=> !loaded_o);

    // R6: event follows an accepted word
    p_loaded_after_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
        loaded_o |-> $past(s_valid && s_ready));

    // R7: stream stays open after completion
    p_drain_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
        loaded_o |-> s_ready);

endmodule

bind pal_stream_loader pal_stream_loader_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .arm_i    (arm_i),
    .s_valid  (s_valid),
    .s_ready  (s_ready),
    .loaded_o (loaded_o),
    .fmt_o    (fmt_o)
);

// File: tb/pal_stream_loader_bench.sv
module pal_stream_loader_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        arm_i = 1'b0;
    logic        s_valid = 1'b0;
    logic [31:0] s_data = '0;
    logic        s_ready;
    logic        loaded_o;
    logic [2:0]  fmt_o;
    logic [7:0]  rd_idx_i = '0;
    logic [11:0] rd_color_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [11:0] mdl [256];

    always #10 clk = ~clk;

    pal_stream_loader u_pal_stream_loader (
        .clk        (clk),
        .rst_n      (rst_n),
        .arm_i      (arm_i),
        .s_valid    (s_valid),
        .s_data     (s_data),
        .s_ready    (s_ready),
        .loaded_o   (loaded_o),
        .fmt_o      (fmt_o),
        .rd_idx_i   (rd_idx_i),
        .rd_color_o (rd_color_o)
    );

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL R6 watchdog expired actual=%0d expected<150000", cycles);
            report();
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int words_of(input int code);
        if (code <= 2) return 65;
        if (code == 3) return 129;
        return 9;
    endfunction

    function automatic logic [11:0] colour_of(input int e, input int l);
        return 12'((e * 37 + l * 91 + 5));
    endfunction

    function automatic logic [15:0] half_of(input int e, input int code, input int l);
        if (e == 0) return {1'b1, 3'(code), colour_of(e, l)};
        return {4'(e * 5 + l), colour_of(e, l)};
    endfunction

    task automatic send(input logic [31:0] d);
        s_valid = 1'b1;
        s_data  = d;
        while (!s_ready) @(negedge clk);
        @(negedge clk);
        s_valid = 1'b0;
    endtask

    task automatic arm();
        arm_i = 1'b1;
        @(negedge clk);
        arm_i = 1'b0;
        check(s_ready == 1'b1, "R2 ready after arm", 32'(s_ready), 1);
    endtask

    task automatic send_entry_word(input int w, input int code, input int l);
        int e0 = 2 * w;
        int e1 = 2 * w + 1;
        if (e0 < 256) mdl[e0] = colour_of(e0, l);
        if (e1 < 256) mdl[e1] = colour_of(e1, l);
        send({half_of(e1, code, l), half_of(e0, code, l)});
    endtask

    task automatic read_all(input string tag);
        for (int i = 0; i < 256; i++) begin
            rd_idx_i = 8'(i);
            @(negedge clk);
            check(rd_color_o == mdl[i], tag, 32'(rd_color_o), 32'(mdl[i]));
        end
    endtask

    task automatic full_load(input int code, input int l, input int extra);
        int n = words_of(code);
        arm();
        for (int w = 0; w < n; w++) begin
            send_entry_word(w, code, l);
            if (w == 0)
                check(fmt_o == 3'(code), "R3 format latched", 32'(fmt_o), 32'(code));
            if (w == n - 1)
                check(loaded_o == 1'b1, "R5 R6 loaded after final word", 32'(loaded_o), 1);
            else
                check(loaded_o == 1'b0, "R5 R6 no early loaded", 32'(loaded_o), 0);
        end
        @(negedge clk);
        check(loaded_o == 1'b0, "R6 loaded one cycle", 32'(loaded_o), 0);
        for (int x = 0; x < extra; x++) begin
            send(32'hFFFF_FFFF ^ 32'(x * 4099));
            check(loaded_o == 1'b0, "R7 no event on surplus", 32'(loaded_o), 0);
            check(s_ready == 1'b1, "R7 surplus accepted", 32'(s_ready), 1);
        end
        check(fmt_o == 3'(code), "R3 format held", 32'(fmt_o), 32'(code));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(s_ready == 1'b0, "R1 reset ready", 32'(s_ready), 0);
        check(loaded_o == 1'b0, "R1 reset loaded", 32'(loaded_o), 0);
        check(fmt_o == 3'd0, "R1 reset fmt", 32'(fmt_o), 0);
        rst_n = 1'b1;
        s_valid = 1'b1;
        s_data  = 32'h0000_7ABC;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(s_ready == 1'b0, "R1 not ready before arm", 32'(s_ready), 0);
            check(fmt_o == 3'd0, "R1 fmt untouched before arm", 32'(fmt_o), 0);
        end
        s_valid = 1'b0;

        // R4 R8: code 3 fills every index; last word's entries 256/257 dropped
        full_load(3, 1, 2);
        read_all("R4 R8 R9 table after 8bpp load");

        // R5 R7: sweep remaining codes with surplus words
        for (int c = 0; c < 8; c++) begin
            if (c != 3) begin
                full_load(c, c + 2, 3);
                read_all("R4 R7 R9 table after load");
            end
        end

        // R10: abandon a transfer partway and restart
        arm();
        for (int w = 0; w < 5; w++) begin
            send_entry_word(w, 3, 20);
            check(loaded_o == 1'b0, "R10 partial no event", 32'(loaded_o), 0);
        end
        full_load(4, 21, 1);
        check(fmt_o == 3'd4, "R10 restart format", 32'(fmt_o), 4);
        read_all("R10 table after restart");

        report();
    end

endmodule